// File: doc/BRIEF.md
# I2C Byte Shift Register with Read Buffer

This block is the byte data path of an I2C controller. It pairs one serial shift register with a separate parallel read buffer and puts both behind a single 32-bit CPU data register. Only the low eight bits carry data. A CPU write goes into the shift register. A CPU read always returns the read buffer and never the live shift register. Serial bits move through the shift register only. They move on shift strobes from the bit-level controller, most significant bit first, for both transmit and receive.

A small sequencer tracks the byte with three states. In `ST_IDLE` no byte is in flight. `ST_SHIFT` counts shifts. `ST_FULL` means eight shifts are complete and the block is waiting for the byte-done strobe. The transitions are:
- IDLE to SHIFT on the first accepted shift strobe.
- SHIFT to FULL on the eighth shift.
- SHIFT to IDLE on an early byte-done, which aborts the byte.
- FULL to IDLE on byte-done. In receive mode this transition also copies the byte into the read buffer.

While the sequencer is not idle, the block reports busy and ignores CPU writes. START/STOP, arbitration, ACK handling and pin drivers belong to other blocks. The data storage has no reset value.

Top module: `i2c_byte_path`

## Requirements
- R1: After reset `busy` is 0.
- R2: A CPU write while idle, with no shift strobe in the same cycle, loads `cpu_wdata[7:0]` into the shift register. On the next cycle `ser_out` equals `cpu_wdata[7]`. Bits [31:8] of the write are ignored.
- R3: `cpu_rdata[7:0]` returns the read buffer. A CPU write or shifting leaves it unchanged. It changes only on a capture.
- R4: Each accepted shift strobe moves the shift register left by one. `ser_in` enters at bit 0. `ser_out` always shows bit 7, so a loaded byte leaves MSB first.
- R5: With `rx_mode`=1, a byte-done strobe in `ST_FULL` copies the eight received bits into the read buffer. The new value is visible on `cpu_rdata` in the next cycle. The first bit received lands in bit 7.
- R6: With `rx_mode`=0, a byte-done strobe leaves the read buffer unchanged.
- R7: `busy` rises in the cycle after the first accepted shift strobe and falls in the cycle after byte-done.
- R8: A CPU write while `busy` is 1 is ignored and does not disturb the byte in the shift register.
- R9: A CPU write in the same cycle as a shift strobe while idle is ignored, and the shift takes place.
- R10: Shift strobes in `ST_FULL` are ignored, so bits after the eighth do not enter the shift register.
- R11: Byte-done before eight shifts returns the block to idle without a capture.
- R12: `cpu_rdata[31:8]` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for the sequencer |
| cpu_wr_en | input | 1 | CPU write strobe |
| cpu_wdata | input | 32 | CPU write data; bits [7:0] used |
| cpu_rdata | output | 32 | Read buffer in bits [7:0], zero above |
| rx_mode | input | 1 | 1 = receive (capture on byte-done), 0 = transmit |
| shift_en | input | 1 | Bit-level shift strobe |
| ser_in | input | 1 | Serial bit shifted in at bit 0 |
| ser_out | output | 1 | Serial bit out, shift register bit 7 |
| byte_done | input | 1 | Byte-complete strobe from the bit-level controller |
| busy | output | 1 | A byte is in flight |

## Verification
A CPU write and a shift strobe can fall in the same cycle. The shift strobe wins, so the write must be dropped. The bench first loads a byte and then drives a write of 0xFF together with a shift strobe. The judgement is based on `ser_out`, on `busy`, and on the byte read back after the byte completes, all compared with the shifted value rather than the written one. Byte-done can also coincide with a shift strobe. That case is covered by an aborted byte, which must leave the read buffer untouched.

// File: rtl/i2cbp_pkg.sv
package i2cbp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_FULL  = 2'd2
    } seq_state_t;

endpackage

// File: rtl/i2cbp_seq.sv
module i2cbp_seq
    import i2cbp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_wr_en,
    input  logic shift_en,
    input  logic byte_done,
    input  logic rx_mode,
    output logic shift_go,
    output logic load_go,
    output logic capture_go,
    output logic busy
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    seq_state_t       state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (shift_go) begin
                    state_nxt = ST_SHIFT;
                    cnt_nxt   = CNT_W'(1);
                end
            end
            ST_SHIFT: begin
                if (byte_done) begin
                    state_nxt = ST_IDLE;
                    cnt_nxt   = '0;
                end else if (shift_go) begin
                    cnt_nxt = cnt + CNT_W'(1);
                    if (cnt == LAST) state_nxt = ST_FULL;
                end
            end
            ST_FULL: begin
                if (byte_done) begin
                    state_nxt = ST_IDLE;
                    cnt_nxt   = '0;
                end
            end
            default: begin
                state_nxt = ST_IDLE;
                cnt_nxt   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        busy       = (state != ST_IDLE);
        shift_go   = shift_en && !byte_done && (state != ST_FULL);
        load_go    = cpu_wr_en && !shift_en && (state == ST_IDLE);
        capture_go = byte_done && rx_mode && (state == ST_FULL);
    end

endmodule

// File: rtl/i2cbp_shifter.sv
module i2cbp_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              load_go,
    input  logic              shift_go,
    input  logic [DATA_W-1:0] load_data,
    input  logic              ser_in,
    output logic [DATA_W-1:0] sreg,
    output logic              ser_out
);
    // data storage carries no reset value
    always_ff @(posedge clk) begin
        if (shift_go)
            sreg <= {sreg[DATA_W-2:0], ser_in};
        else if (load_go)
            sreg <= load_data;
    end

    assign ser_out = sreg[DATA_W-1];

endmodule

// File: rtl/i2cbp_rdbuf.sv
module i2cbp_rdbuf #(
    parameter int DATA_W = 8,
    parameter int BUS_W  = 32
) (
    input  logic              clk,
    input  logic              capture_go,
    input  logic [DATA_W-1:0] sreg,
    output logic [BUS_W-1:0]  rdata
);
    localparam int PAD_W = BUS_W - DATA_W;

    logic [DATA_W-1:0] buf_q;

    always_ff @(posedge clk) begin
        if (capture_go) buf_q <= sreg;
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign rdata = {{PAD_W{1'b0}}, buf_q};
        end else begin : g_nopad
            assign rdata = buf_q;
        end
    endgenerate

endmodule

// File: rtl/i2c_byte_path.sv
module i2c_byte_path #(
    parameter int DATA_W = 8,
    parameter int BUS_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr_en,
    input  logic [BUS_W-1:0] cpu_wdata,
    output logic [BUS_W-1:0] cpu_rdata,
    input  logic             rx_mode,
    input  logic             shift_en,
    input  logic             ser_in,
    output logic             ser_out,
    input  logic             byte_done,
    output logic             busy
);
    logic              shift_go, load_go, capture_go;
    logic [DATA_W-1:0] sreg;

    i2cbp_seq #(.DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_wr_en  (cpu_wr_en),
        .shift_en   (shift_en),
        .byte_done  (byte_done),
        .rx_mode    (rx_mode),
        .shift_go   (shift_go),
        .load_go    (load_go),
        .capture_go (capture_go),
        .busy       (busy)
    );

    i2cbp_shifter #(.DATA_W(DATA_W)) u_shf (
        .clk       (clk),
        .load_go   (load_go),
        .shift_go  (shift_go),
        .load_data (cpu_wdata[DATA_W-1:0]),
        .ser_in    (ser_in),
        .sreg      (sreg),
        .ser_out   (ser_out)
    );

    i2cbp_rdbuf #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_buf (
        .clk        (clk),
        .capture_go (capture_go),
        .sreg       (sreg),
        .rdata      (cpu_rdata)
    );

endmodule

// File: rtl/i2cbp_chk.sv
module i2cbp_chk #(
    parameter int DATA_W = 8,
    parameter int BUS_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_wr_en,
    input logic [BUS_W-1:0] cpu_wdata,
    input logic [BUS_W-1:0] cpu_rdata,
    input logic             shift_en,
    input logic             ser_out,
    input logic             byte_done,
    input logic             busy
);
    assert_busy_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !byte_done && !busy) |=> busy);

    assert_busy_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !busy);

    assert_rsvd_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata[BUS_W-1:DATA_W] == '0);

    assert_buf_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_done |=> $stable(cpu_rdata));

    assert_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !shift_en) |=> $stable(ser_out));

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cpu_wr_en && !shift_en) |=> (ser_out == $past(cpu_wdata[DATA_W-1])));

endmodule

bind i2c_byte_path i2cbp_chk #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_wr_en (cpu_wr_en),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .shift_en  (shift_en),
    .ser_out   (ser_out),
    .byte_done (byte_done),
    .busy      (busy)
);

// File: tb/sim_i2c_byte_path.sv
`timescale 1ns/1ps
module sim_i2c_byte_path;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr_en = 1'b0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        rx_mode = 1'b0;
    logic        shift_en = 1'b0;
    logic        ser_in = 1'b0;
    logic        ser_out;
    logic        byte_done = 1'b0;
    logic        busy;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    i2c_byte_path u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic cpu_write(input logic [31:0] d);
        cpu_wr_en = 1'b1; cpu_wdata = d; tick();
        cpu_wr_en = 1'b0; cpu_wdata = '0;
    endtask

    task automatic shift1(input logic b);
        shift_en = 1'b1; ser_in = b; tick();
        shift_en = 1'b0; ser_in = 1'b0;
    endtask

    task automatic finish_byte(input logic rx);
        rx_mode = rx; byte_done = 1'b1; tick();
        byte_done = 1'b0;
    endtask

    task automatic receive(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) shift1(b[i]);
        finish_byte(1'b1);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R1 busy after reset", 32'(busy), 0);
        chk(cpu_rdata[31:8] == '0, "R12 reserved after reset", cpu_rdata, 0);
    endtask

    task automatic t_receive();
        receive(8'hC3);
        chk(cpu_rdata == 32'hC3, "R5 rx byte C3", cpu_rdata, 32'hC3);
        chk(busy == 1'b0, "R7 busy low after done", 32'(busy), 0);
        receive(8'h5A);
        chk(cpu_rdata == 32'h5A, "R5 rx byte 5A", cpu_rdata, 32'h5A);
    endtask

    task automatic t_transmit();
        logic [7:0] d = 8'h96;
        cpu_write(32'hABCD_EF96);
        chk(cpu_rdata == 32'h5A, "R3 read ignores write", cpu_rdata, 32'h5A);
        chk(ser_out == 1'b1, "R2 load msb", 32'(ser_out), 1);
        for (int i = 7; i >= 0; i--) begin
            chk(ser_out == d[i], "R4 msb-first bit", 32'(ser_out), 32'(d[i]));
            shift1(1'b0);
            if (i == 7) chk(busy == 1'b1, "R7 busy after first shift", 32'(busy), 1);
        end
        chk(cpu_rdata == 32'h5A, "R3 read ignores shifting", cpu_rdata, 32'h5A);
        finish_byte(1'b0);
        chk(cpu_rdata == 32'h5A, "R6 tx done no capture", cpu_rdata, 32'h5A);
        chk(busy == 1'b0, "R7 busy low after tx done", 32'(busy), 0);
    endtask

    task automatic t_write_busy();
        logic [7:0] b = 8'h3C;
        for (int i = 7; i >= 0; i--) begin
            shift1(b[i]);
            if (i == 4) cpu_write(32'h0000_00FF);
        end
        cpu_write(32'h0000_0000);
        finish_byte(1'b1);
        chk(cpu_rdata == 32'h3C, "R8 write while busy ignored", cpu_rdata, 32'h3C);
    endtask

    task automatic t_write_vs_shift();
        cpu_write(32'h0000_00A5);
        cpu_wr_en = 1'b1; cpu_wdata = 32'hFF; shift_en = 1'b1; ser_in = 1'b1; tick();
        cpu_wr_en = 1'b0; cpu_wdata = '0; shift_en = 1'b0; ser_in = 1'b0;
        // shifted value 0x4B: bit7 = 0; a won write would give 1
        chk(ser_out == 1'b0, "R9 shift wins over write", 32'(ser_out), 0);
        chk(busy == 1'b1, "R9 busy after shift", 32'(busy), 1);
        for (int i = 0; i < 7; i++) shift1(1'b0);
        finish_byte(1'b1);
        chk(cpu_rdata == 32'h80, "R9 captured shifted byte", cpu_rdata, 32'h80);
    endtask

    task automatic t_extra_shift();
        logic [7:0] b = 8'h69;
        for (int i = 7; i >= 0; i--) shift1(b[i]);
        shift1(1'b1);
        shift1(1'b0);
        finish_byte(1'b1);
        chk(cpu_rdata == 32'h69, "R10 extra shifts ignored", cpu_rdata, 32'h69);
    endtask

    task automatic t_abort();
        for (int i = 0; i < 4; i++) shift1(1'b1);
        finish_byte(1'b1);
        chk(cpu_rdata == 32'h69, "R11 abort no capture", cpu_rdata, 32'h69);
        chk(busy == 1'b0, "R11 idle after abort", 32'(busy), 0);
        // abort with byte_done and shift in the same cycle
        for (int i = 0; i < 7; i++) shift1(1'b0);
        shift_en = 1'b1; ser_in = 1'b1; rx_mode = 1'b1; byte_done = 1'b1; tick();
        shift_en = 1'b0; ser_in = 1'b0; byte_done = 1'b0;
        chk(busy == 1'b0 && cpu_rdata == 32'h69, "R11 done beats shift", cpu_rdata, 32'h69);
        receive(8'hF0);
        chk(cpu_rdata == 32'hF0, "R5 rx after abort", cpu_rdata, 32'hF0);
        chk(cpu_rdata[31:8] == '0, "R12 reserved zero", cpu_rdata, 32'hF0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_receive();
        t_transmit();
        t_write_busy();
        t_write_vs_shift();
        t_extra_shift();
        t_abort();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule